// File: doc/BRIEF.md
# Quarter-Wave Sine Synthesizer

This block is a direct digital frequency synthesizer. A 32-bit phase register advances by a programmable tuning word on every clock. The upper 12 bits of that register, plus a phase offset, form the phase that drives a phase-to-amplitude converter. The converter produces a 12-bit signed sine sample. It has neither a lookup memory nor a multiplier.

The converter folds the phase into a single quarter wave. It does this by ones'-complementing the in-quadrant bits in the second and fourth quadrants, and by negating the result in the lower half cycle. Inside the quarter, a 3-bit segment index selects a base amplitude and a slope. The slope is the sum of two power-of-two shifts of the 7-bit sub-angle, so the amplitude is the sum of three integers.

A second converter produces a cosine sample. It uses the same structure, driven by the phase plus a quarter cycle. Both outputs are free-running streams with one new sample per clock. Neither has a handshake, because a synthesizer cannot stall its own time base. The output frequency is tune_word × f_clk / 2^32.

Top module: `dds_sine_synth`

## Requirements
- R1: While rst is high at a rising edge, both outputs read 0 after that edge, and the phase register restarts from 0.
- R2: At each rising edge with rst low, tune_word is added to the 32-bit phase register, modulo 2^32. The converter phase is register bits [31:20] plus phase_ofs, modulo 4096.
- R3: A phase change reaches the outputs on the second rising edge after the edge that samples it. A new phase_ofs therefore shows on the second edge after it is applied, and a new tune_word shows on the third.
- R4: For every phase p, sin_out differs from round(2047·sin(2π·p/4096)) by at most 24.
- R5: The sample at phase p+2048 is exactly the negative of the sample at p. A negative sample only comes from a phase whose bit 11 is set.
- R6: The sample at phase 1024+k equals the sample at phase 1023−k, for k = 0..1023. This is the ones'-complement mirror of the second quadrant.
- R7: cos_out at phase p equals exactly sin_out at phase (p+1024) mod 4096. It also stays within 24 of round(2047·cos(2π·p/4096)).
- R8: Phase bits [11:10] are the quadrant, bits [9:7] the segment and bits [6:0] the sub-angle. The magnitude is the segment base plus two shifted copies of the sub-angle, saturated at 2047. Outputs are two's complement in the range −2047..2047 and never −2048.
- R9: Phases 0 and 2048 give 0, phase 1024 gives 2047, and phase 3072 gives −2047.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 32 | Phase increment added every clock |
| phase_ofs | input | 12 | Offset added to the truncated phase |
| sin_out | output | 12 | Signed sine sample |
| cos_out | output | 12 | Signed cosine sample, a quarter cycle ahead of sin_out |

## Verification
An offset presented between two edges is captured on the first edge and appears on the outputs after the second. A tuning word takes one more edge, because it must first move the phase register. The bench keeps its own model of the phase register and pushes the expected phase at every rising edge. It pops and compares at each falling edge only once two entries are queued, so every comparison lands on the cycle in which that phase's sample is due. The latency is also probed directly: after an offset step, the old value is checked one edge later and the new one two edges later.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;
  // quarter-wave geometry of the 12-bit phase
  localparam int SEG_W  = 3;
  localparam int SUB_W  = 7;
  localparam int MAG_W  = 11;
  localparam int TERM_W = SUB_W + 1;

  // shift applied to the sub-angle for one slope term
  typedef enum logic [2:0] {
    SH_UP1  = 3'd0,
    SH_UNIT = 3'd1,
    SH_DN1  = 3'd2,
    SH_DN2  = 3'd3,
    SH_DN3  = 3'd4,
    SH_DN4  = 3'd5,
    SH_NONE = 3'd6
  } slope_sh_e;

  typedef struct packed {
    logic [MAG_W-1:0] base;
    slope_sh_e        hi;
    slope_sh_e        lo;
  } seg_coef_t;

  // base is the start amplitude nudged to centre the error; slope ~ chord/128
  function automatic seg_coef_t seg_coef(input logic [SEG_W-1:0] s);
    seg_coef_t c;
    case (s)
      3'd0:    c = '{base: 11'd0,    hi: SH_UP1,  lo: SH_UNIT}; // 3.0
      3'd1:    c = '{base: 11'd400,  hi: SH_UP1,  lo: SH_UNIT}; // 3.0
      3'd2:    c = '{base: 11'd768,  hi: SH_UP1,  lo: SH_UNIT}; // 3.0
      3'd3:    c = '{base: 11'd1133, hi: SH_UP1,  lo: SH_DN1};  // 2.5
      3'd4:    c = '{base: 11'd1450, hi: SH_UP1,  lo: SH_NONE}; // 2.0
      3'd5:    c = '{base: 11'd1704, hi: SH_UNIT, lo: SH_DN1};  // 1.5
      3'd6:    c = '{base: 11'd1888, hi: SH_UNIT, lo: SH_NONE}; // 1.0
      default: c = '{base: 11'd2012, hi: SH_DN2,  lo: SH_DN4};  // 0.3125
    endcase
    return c;
  endfunction

  function automatic logic [TERM_W-1:0] shift_term(input logic [SUB_W-1:0] v,
                                                   input slope_sh_e k);
    logic [TERM_W-1:0] t;
    case (k)
      SH_UP1:  t = {v, 1'b0};
      SH_UNIT: t = {1'b0, v};
      SH_DN1:  t = {1'b0, (v >> 1)};
      SH_DN2:  t = {1'b0, (v >> 2)};
      SH_DN3:  t = {1'b0, (v >> 3)};
      SH_DN4:  t = {1'b0, (v >> 4)};
      default: t = '0;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] tune_i,
  input  logic [PH_W-1:0]  ofs_i,
  output logic [PH_W-1:0]  phase_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_q + tune_i;
  end

  // truncated phase plus offset, wraps modulo 2^PH_W
  assign phase_o = acc_q[ACC_W-1 -: PH_W] + ofs_i;
endmodule

// File: rtl/dds_seg_interp.sv
`timescale 1ns/1ps
module dds_seg_interp import dds_pkg::*; (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [SUB_W-1:0] sub_i,
  output logic [MAG_W-1:0] mag_o
);
  seg_coef_t        coef;
  logic [MAG_W:0]   sum;

  always_comb begin
    coef  = seg_coef(seg_i);
    // three-integer sum: base + two shifted sub-angle copies
    sum   = {1'b0, coef.base}
          + (MAG_W+1)'(shift_term(sub_i, coef.hi))
          + (MAG_W+1)'(shift_term(sub_i, coef.lo));
    mag_o = sum[MAG_W] ? {MAG_W{1'b1}} : sum[MAG_W-1:0];
  end
endmodule

// File: rtl/dds_quarter_amp.sv
`timescale 1ns/1ps
module dds_quarter_amp import dds_pkg::*; #(
  parameter int PH_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PH_W-1:0]         phase_i,
  output logic signed [MAG_W:0]   amp_o
);
  localparam int QW = PH_W - 2;

  logic [1:0]       quad;
  logic [QW-1:0]    low;
  logic [QW-1:0]    fold;
  logic [MAG_W-1:0] mag_c;
  logic [MAG_W-1:0] mag_q;
  logic             neg_q;

  assign quad = phase_i[PH_W-1 -: 2];
  assign low  = phase_i[QW-1:0];
  // second and fourth quadrants run the sawtooth backwards
  assign fold = quad[0] ? ~low : low;

  dds_seg_interp u_interp (
    .seg_i (fold[QW-1 -: SEG_W]),
    .sub_i (fold[SUB_W-1:0]),
    .mag_o (mag_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0;
      neg_q <= 1'b0;
      amp_o <= '0;
    end else begin
      mag_q <= mag_c;
      neg_q <= quad[1];
      amp_o <= neg_q ? -$signed({1'b0, mag_q}) : $signed({1'b0, mag_q});
    end
  end

  // R9
  axis_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_i[PH_W-2:0] == '0) |=> (mag_q == '0));

  // R9
  crest_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_i[PH_W-2:0] == {1'b1, {(PH_W-2){1'b0}}}) |=> (mag_q == {MAG_W{1'b1}}));
endmodule

// File: rtl/dds_sine_synth.sv
`timescale 1ns/1ps
module dds_sine_synth import dds_pkg::*; #(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 12,
  parameter bit COS_EN = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ACC_W-1:0]      tune_word,
  input  logic [PH_W-1:0]       phase_ofs,
  output logic signed [MAG_W:0] sin_out,
  output logic signed [MAG_W:0] cos_out
);
  localparam logic [PH_W-1:0] QUARTER = {2'b01, {(PH_W-2){1'b0}}};

  logic [PH_W-1:0] phase_w;

  dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .tune_i  (tune_word),
    .ofs_i   (phase_ofs),
    .phase_o (phase_w)
  );

  dds_quarter_amp #(.PH_W(PH_W)) u_sin (
    .clk     (clk),
    .rst     (rst),
    .phase_i (phase_w),
    .amp_o   (sin_out)
  );

  generate
    if (COS_EN) begin : g_cos
      logic [PH_W-1:0] cos_phase;
      assign cos_phase = phase_w + QUARTER;
      dds_quarter_amp #(.PH_W(PH_W)) u_cos (
        .clk     (clk),
        .rst     (rst),
        .phase_i (cos_phase),
        .amp_o   (cos_out)
      );
    end else begin : g_nocos
      assign cos_out = '0;
    end
  endgenerate

  // cycles since reset, used to keep $past inside the post-reset window
  logic [2:0] live_q;
  always_ff @(posedge clk) begin
    if (rst)                 live_q <= '0;
    else if (live_q != 3'd7) live_q <= live_q + 3'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sin_out == '0 && cos_out == '0));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q == 3'd7 && $past(tune_word, 3) == '0 &&
     $past(phase_ofs, 2) == $past(phase_ofs, 3)) |-> $stable(sin_out));

  // R5
  lower_half_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q == 3'd7 && sin_out[MAG_W]) |-> $past(phase_w[PH_W-1], 2));
endmodule

// File: tb/test_dds_sine_synth.sv
`timescale 1ns/1ps
module test_dds_sine_synth;
  localparam real PI    = 3.141592653589793;
  localparam int  BOUND = 24;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [31:0]        tw  = '0;
  logic [11:0]        ofs = '0;
  logic signed [11:0] sin_out;
  logic signed [11:0] cos_out;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  int s_arr [4096];
  int c_arr [4096];
  int exp_q [$];
  bit [31:0] bacc = '0;

  always #2 clk = ~clk;

  dds_sine_synth i_dds_sine_synth (
    .clk       (clk),
    .rst       (rst),
    .tune_word (tw),
    .phase_ofs (ofs),
    .sin_out   (sin_out),
    .cos_out   (cos_out)
  );

  task automatic chk(input string req, input int act, input int exp, input bit ok);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ideal(input int p, input bit cosine);
    real a = 2.0 * PI * real'(p) / 4096.0;
    return cosine ? int'(2047.0 * $cos(a)) : int'(2047.0 * $sin(a));
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // driver side of the scoreboard: expected phase per edge (R2 model)
  always @(posedge clk) begin
    if (rst) begin
      exp_q.delete();
      bacc = '0;
    end else begin
      logic [11:0] ph;
      ph = bacc[31:20] + ofs;
      exp_q.push_back(int'(ph));
      bacc = bacc + tw;
    end
  end

  // monitor: the sample for an edge's phase is due after the next edge (R3)
  always @(negedge clk) begin
    if (!rst && exp_q.size() >= 2) begin
      int p;
      int s;
      int c;
      p = exp_q.pop_front();
      s = int'(sin_out);
      c = int'(cos_out);
      chk("R4 sine error", s, ideal(p, 1'b0), iabs(s - ideal(p, 1'b0)) <= BOUND);
      chk("R7 cosine error", c, ideal(p, 1'b1), iabs(c - ideal(p, 1'b1)) <= BOUND);
      chk("R8 range", s, 0, s >= -2047 && s <= 2047 && c >= -2047 && c <= 2047);
      s_arr[p] = s;
      c_arr[p] = c;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sin in reset", int'(sin_out), 0, sin_out == 0);
    chk("R1 cos in reset", int'(cos_out), 0, cos_out == 0);
    rst = 1'b0;

    // R3 explicit latency probe on an offset step
    repeat (4) @(negedge clk);
    ofs = 12'd1024;
    @(negedge clk);
    chk("R3 old value one edge later", int'(sin_out), 0, sin_out == 0);
    @(negedge clk);
    chk("R3 new value two edges later", int'(sin_out), 2047, sin_out == 2047);

    // full phase sweep through the offset, tuning word zero
    for (int p = 0; p < 4096; p++) begin
      @(negedge clk);
      ofs = 12'(p);
    end
    repeat (3) @(negedge clk);

    // R5 odd symmetry
    for (int p = 0; p < 2048; p++)
      chk("R5 odd symmetry", s_arr[p + 2048], -s_arr[p], s_arr[p + 2048] == -s_arr[p]);
    // R6 mirror within each half
    for (int k = 0; k < 1024; k++) begin
      chk("R6 mirror upper", s_arr[1024 + k], s_arr[1023 - k], s_arr[1024 + k] == s_arr[1023 - k]);
      chk("R6 mirror lower", s_arr[3072 + k], s_arr[3071 - k], s_arr[3072 + k] == s_arr[3071 - k]);
    end
    // R7 cosine is the sine a quarter cycle on
    for (int p = 0; p < 4096; p++)
      chk("R7 cosine exact", c_arr[p], s_arr[(p + 1024) % 4096], c_arr[p] == s_arr[(p + 1024) % 4096]);
    // R9 landmarks
    chk("R9 phase 0", s_arr[0], 0, s_arr[0] == 0);
    chk("R9 phase 2048", s_arr[2048], 0, s_arr[2048] == 0);
    chk("R9 phase 1024", s_arr[1024], 2047, s_arr[1024] == 2047);
    chk("R9 phase 3072", s_arr[3072], -2047, s_arr[3072] == -2047);

    // R2 accumulator runs: scoreboard compares each sample against the model
    ofs = 12'd0;
    tw  = 32'h0010_0000;
    repeat (300) @(negedge clk);
    tw  = 32'h0008_0000;
    repeat (300) @(negedge clk);
    tw  = 32'h0123_4567;
    repeat (250) @(negedge clk);
    ofs = 12'd700;
    repeat (250) @(negedge clk);

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R1 sin after reset edge", int'(sin_out), 0, sin_out == 0);
    chk("R1 cos after reset edge", int'(cos_out), 0, cos_out == 0);
    // R1 phase restarts at zero: with offset 0 the first sample is phase 0
    ofs = 12'd0;
    tw  = 32'h0010_0000;
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 restart from phase 0", int'(sin_out), 0, sin_out == 0);
    @(negedge clk);
    chk("R2 one step per clock", int'(sin_out), ideal(1, 1'b0),
        iabs(int'(sin_out) - ideal(1, 1'b0)) <= BOUND);
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule